// File: doc/BRIEF.md
# Partitioned secure RAM guard

The guard sits in front of an on-chip secure memory and decides, on every bus request, whether the request may touch the addressed word. The memory is divided into equal pages. Each page holds a small ownership record: whether it has been assigned at all, which resource domain owns it, whether it is reserved for secure-world requesters, and separate read and write permissions. A request carries a domain identifier and a secure/non-secure flag. A request that fails any check is answered with an error response and zero data, and a rejected write does not alter the memory.

Only one designated manager domain may write page records, through a dedicated configuration port. A hardware security-violation input starts an automatic wipe. The wipe writes zero to every word, one word per cycle. While it runs, every access is refused. When it finishes, a done flag is raised. The page records survive the wipe. The wipe length is a parameter. Production use selects 16 pages of 1024 words, which gives 64 KB. The default build uses 16 pages of 64 words, and every requirement below is stated for that default.

Top module: `secram_guard`

## Requirements
- R1: After a synchronous active-low reset, every page is unassigned, `rsp_valid`, `cfg_rsp_valid`, `zero_busy` and `zero_done` are 0.
- R2: Every cycle with `req_valid` high produces exactly one cycle of `rsp_valid` high on the next clock edge. A cycle without a request produces none.
- R3: `req_addr` is a 10-bit word address: bits [9:6] pick one of 16 pages and bits [5:0] the 32-bit word inside it. A granted write followed by a granted read of the same address returns the written data.
- R4: A page whose record is unassigned refuses every access, whoever sends it.
- R5: A request whose `req_did` differs from the page owner is refused.
- R6: A non-secure request (`req_secure`=0) to a page marked secure-only is refused even when the domain matches. A secure request to a page not marked secure-only is granted.
- R7: Reads need the page's read permission and writes need its write permission, each checked independently.
- R8: A refused request returns `rsp_err`=1 with `rsp_rdata`=0. A refused write leaves the addressed word unchanged.
- R9: A configuration command is applied only when `cfg_did` equals the manager domain 15. Otherwise it answers `cfg_rsp_err`=1 and changes nothing. Either way `cfg_rsp_valid` pulses on the next edge, and a new record governs requests from the following cycle.
- R10: `viol_in` sampled high starts a wipe. `zero_busy` rises on that edge and stays high for exactly 1024 cycles, after which every word reads 0. `zero_done` then rises and stays set until the next wipe starts.
- R11: Requests sampled while `zero_busy` is high, or in the cycle `viol_in` is high, are refused. Page records are kept across a wipe.
- R12: A `viol_in` pulse during a running wipe restarts it from the first word, giving a further 1024 busy cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 10 | Word address: page in [9:6], word in [5:0] |
| req_wdata | input | 32 | Write data |
| req_did | input | 4 | Requesting domain |
| req_secure | input | 1 | 1 = secure-world requester |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_err | output | 1 | Request was refused |
| rsp_rdata | output | 32 | Read data, zero on error or write |
| cfg_valid | input | 1 | Page record write command |
| cfg_did | input | 4 | Domain issuing the command |
| cfg_page | input | 4 | Page to configure |
| cfg_owner | input | 4 | New owning domain |
| cfg_assigned | input | 1 | Page is assigned |
| cfg_secure | input | 1 | Page is secure-only |
| cfg_rd | input | 1 | Read permission |
| cfg_wr | input | 1 | Write permission |
| cfg_rsp_valid | output | 1 | Command answered |
| cfg_rsp_err | output | 1 | Command refused (not the manager) |
| viol_in | input | 1 | Security violation, starts a wipe |
| zero_busy | output | 1 | Wipe in progress |
| zero_done | output | 1 | Last wipe completed |

## Verification
A corrupted page record shows up one cycle after the first request to that page. Depending on the corruption, the response carries an error where a grant was due, or data where zero was due. The bench therefore sweeps every page against every domain and both privilege values. A wrong wipe counter shows as a busy window that is not exactly 1024 cycles, or as non-zero words read back right after `zero_done`. A write-mux fault shows only when the affected word is read again, so each rejected-write test ends with a full readback of the page.

// File: rtl/secram_pkg.sv
// Shared types for the secure RAM guard.
// Assumes: nothing beyond IEEE 1800-2017 packed types.
package secram_pkg;

    // Per-page attribute bits; the owner domain is held separately because
    // its width is a module parameter.
    typedef struct packed {
        logic assigned;     // page has been handed out by the manager
        logic secure_only;  // only secure-world requesters may enter
        logic rd_ok;        // reads permitted
        logic wr_ok;        // writes permitted
    } page_attr_t;

    // Outcome of the access check, first failing rule wins.
    typedef enum logic [2:0] {
        VERDICT_GRANT   = 3'd0,
        VERDICT_WIPING  = 3'd1,
        VERDICT_UNOWNED = 3'd2,
        VERDICT_FOREIGN = 3'd3,
        VERDICT_PRIV    = 3'd4,
        VERDICT_NOPERM  = 3'd5
    } verdict_t;

endpackage

// File: rtl/secram_page_table.sv
// Page ownership table. Holds one record per page and applies configuration
// commands that come from the manager domain only. It answers every command
// one cycle later. The lookup side is combinational on the requested page.
// Assumes: one command per cycle, cfg_page always below PAGES.
module secram_page_table
    import secram_pkg::*;
#(
    parameter int unsigned          PAGE_BITS = 4,
    parameter int unsigned          DID_W     = 4,
    parameter logic [DID_W-1:0]     MGR_DID   = '1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_valid,
    input  logic [DID_W-1:0]     cfg_did,
    input  logic [PAGE_BITS-1:0] cfg_page,
    input  logic [DID_W-1:0]     cfg_owner,
    input  page_attr_t           cfg_attr,
    output logic                 cfg_rsp_valid,
    output logic                 cfg_rsp_err,
    input  logic [PAGE_BITS-1:0] look_page,
    output page_attr_t           look_attr,
    output logic [DID_W-1:0]     look_owner
);
    localparam int unsigned PAGES = 1 << PAGE_BITS;

    page_attr_t       attr_q  [PAGES];
    logic [DID_W-1:0] owner_q [PAGES];
    logic             from_mgr;

    assign from_mgr = (cfg_did == MGR_DID);

    // Record storage: cleared at reset, written by accepted commands.
    always_ff @(posedge clk) begin
        for (int p = 0; p < PAGES; p++) begin
            if (!rst_n) begin
                attr_q[p]  <= '0;
                owner_q[p] <= '0;
            end else if (cfg_valid && from_mgr && (cfg_page == PAGE_BITS'(p))) begin
                attr_q[p]  <= cfg_attr;
                owner_q[p] <= cfg_owner;
            end
        end
    end

    // Command answer: one pulse per command, error flag for non-managers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_rsp_valid <= 1'b0;
            cfg_rsp_err   <= 1'b0;
        end else begin
            cfg_rsp_valid <= cfg_valid;
            cfg_rsp_err   <= cfg_valid && !from_mgr;
        end
    end

    // Lookup for the access path.
    always_comb begin
        look_attr  = attr_q[look_page];
        look_owner = owner_q[look_page];
    end

    AST_CFG_FOREIGN_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid && (cfg_did != MGR_DID)) |=> (cfg_rsp_valid && cfg_rsp_err)); // R9

    AST_CFG_RECORD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_valid && $past(rst_n)) |=> $stable(attr_q[0])); // R9

endmodule

// File: rtl/secram_access_check.sv
// Access rule evaluation. It compares a request with the record of the
// addressed page and returns the first rule that fails, or a grant.
// Assumes: the record and owner are already looked up for the same page.
module secram_access_check
    import secram_pkg::*;
#(
    parameter int unsigned DID_W = 4
) (
    input  logic             blocked,
    input  logic             req_write,
    input  logic [DID_W-1:0] req_did,
    input  logic             req_secure,
    input  page_attr_t       attr,
    input  logic [DID_W-1:0] owner,
    output verdict_t         verdict,
    output logic             grant
);
    // Priority chain: wipe, assignment, domain, privilege, permission.
    always_comb begin
        if (blocked)                            verdict = VERDICT_WIPING;
        else if (!attr.assigned)                verdict = VERDICT_UNOWNED;
        else if (owner != req_did)              verdict = VERDICT_FOREIGN;
        else if (attr.secure_only && !req_secure) verdict = VERDICT_PRIV;
        else if (req_write ? !attr.wr_ok : !attr.rd_ok) verdict = VERDICT_NOPERM;
        else                                    verdict = VERDICT_GRANT;
    end

    // Single grant line for the datapath.
    assign grant = (verdict == VERDICT_GRANT);

endmodule

// File: rtl/secram_zeroizer.sv
// Wipe sequencer. A violation starts, or restarts, a walk that offers one
// zero write per cycle over every word index. It raises done at the end.
// Assumes: WORDS is a power of two.
module secram_zeroizer #(
    parameter int unsigned WORDS = 1024,
    localparam int unsigned IDX_W = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             busy,
    output logic             done,
    output logic [IDX_W-1:0] idx
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(WORDS - 1);

    // Walk state: start wins over the running walk.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            done <= 1'b0;
            idx  <= '0;
        end else if (start) begin
            busy <= 1'b1;
            done <= 1'b0;
            idx  <= '0;
        end else if (busy) begin
            if (idx == LAST) begin
                busy <= 1'b0;
                done <= 1'b1;
            end
            idx <= idx + 1'b1;
        end
    end

    AST_WIPE_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (busy && !done && (idx == '0))); // R12

    AST_DONE_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R10

endmodule

// File: rtl/secram_store.sv
// Single-port-style word memory with one write and one registered read per
// cycle. Assumes the caller never reads and writes the same word in one
// cycle when the read result matters.
module secram_store #(
    parameter int unsigned WORDS  = 1024,
    parameter int unsigned DATA_W = 32,
    localparam int unsigned ADDR_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [WORDS];

    // Array write port.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Registered read port.
    always_ff @(posedge clk) begin
        if (!rst_n)  rdata <= '0;
        else if (re) rdata <= mem[raddr];
    end

endmodule

// File: rtl/secram_guard.sv
// Top level of the secure RAM guard. It looks up the page record for each
// request and evaluates the access rules. Granted requests go to the store,
// and every request gets a registered response. A violation hands the
// store's write port to the wipe sequencer.
// Assumes: one request per cycle; responses are never back-pressured.
module secram_guard
    import secram_pkg::*;
#(
    parameter int unsigned      PAGE_BITS = 4,
    parameter int unsigned      OFF_BITS  = 6,
    parameter int unsigned      DATA_W    = 32,
    parameter int unsigned      DID_W     = 4,
    parameter logic [DID_W-1:0] MGR_DID   = '1,
    localparam int unsigned     ADDR_W    = PAGE_BITS + OFF_BITS,
    localparam int unsigned     WORDS     = 1 << ADDR_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [DATA_W-1:0]    req_wdata,
    input  logic [DID_W-1:0]     req_did,
    input  logic                 req_secure,
    output logic                 rsp_valid,
    output logic                 rsp_err,
    output logic [DATA_W-1:0]    rsp_rdata,
    input  logic                 cfg_valid,
    input  logic [DID_W-1:0]     cfg_did,
    input  logic [PAGE_BITS-1:0] cfg_page,
    input  logic [DID_W-1:0]     cfg_owner,
    input  logic                 cfg_assigned,
    input  logic                 cfg_secure,
    input  logic                 cfg_rd,
    input  logic                 cfg_wr,
    output logic                 cfg_rsp_valid,
    output logic                 cfg_rsp_err,
    input  logic                 viol_in,
    output logic                 zero_busy,
    output logic                 zero_done
);
    page_attr_t        cfg_attr;
    page_attr_t        look_attr;
    logic [DID_W-1:0]  look_owner;
    verdict_t          verdict;
    logic              grant;
    logic [ADDR_W-1:0] wipe_idx;
    logic              user_we;
    logic              user_re;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr;
    logic [DATA_W-1:0] mem_wdata;
    logic [DATA_W-1:0] mem_rdata;
    logic              ok_q;
    logic              rd_q;

    assign cfg_attr = '{assigned: cfg_assigned, secure_only: cfg_secure,
                        rd_ok: cfg_rd, wr_ok: cfg_wr};

    secram_page_table #(
        .PAGE_BITS (PAGE_BITS),
        .DID_W     (DID_W),
        .MGR_DID   (MGR_DID)
    ) u_table (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_valid     (cfg_valid),
        .cfg_did       (cfg_did),
        .cfg_page      (cfg_page),
        .cfg_owner     (cfg_owner),
        .cfg_attr      (cfg_attr),
        .cfg_rsp_valid (cfg_rsp_valid),
        .cfg_rsp_err   (cfg_rsp_err),
        .look_page     (req_addr[ADDR_W-1:OFF_BITS]),
        .look_attr     (look_attr),
        .look_owner    (look_owner)
    );

    secram_access_check #(
        .DID_W (DID_W)
    ) u_check (
        .blocked    (zero_busy || viol_in),
        .req_write  (req_write),
        .req_did    (req_did),
        .req_secure (req_secure),
        .attr       (look_attr),
        .owner      (look_owner),
        .verdict    (verdict),
        .grant      (grant)
    );

    secram_zeroizer #(
        .WORDS (WORDS)
    ) u_wipe (
        .clk   (clk),
        .rst_n (rst_n),
        .start (viol_in),
        .busy  (zero_busy),
        .done  (zero_done),
        .idx   (wipe_idx)
    );

    // Granted user traffic toward the store.
    assign user_we = req_valid && grant && req_write;
    assign user_re = req_valid && grant && !req_write;

    // Write-port owner: the wipe has priority over any user write.
    always_comb begin
        if (zero_busy) begin
            mem_we    = 1'b1;
            mem_waddr = wipe_idx;
            mem_wdata = '0;
        end else begin
            mem_we    = user_we;
            mem_waddr = req_addr;
            mem_wdata = req_wdata;
        end
    end

    secram_store #(
        .WORDS  (WORDS),
        .DATA_W (DATA_W)
    ) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .re    (user_re),
        .raddr (req_addr),
        .rdata (mem_rdata)
    );

    // Response tracking: one registered answer per request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            ok_q      <= 1'b0;
            rd_q      <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            ok_q      <= req_valid && grant;
            rd_q      <= req_valid && !req_write;
        end
    end

    // Response outputs: data only for granted reads.
    assign rsp_err   = rsp_valid && !ok_q;
    assign rsp_rdata = (ok_q && rd_q) ? mem_rdata : '0;

    AST_ONE_RSP_PER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R2

    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid); // R2

    AST_UNOWNED_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !look_attr.assigned) |=> rsp_err); // R4

    AST_FOREIGN_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (look_owner != req_did)) |=> rsp_err); // R5

    AST_NS_ON_SECURE_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && look_attr.secure_only && !req_secure) |=> rsp_err); // R6

    AST_ERR_CARRIES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_rdata == '0)); // R8

    AST_WIPE_BLOCKS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (zero_busy || viol_in)) |=> rsp_err); // R11

    AST_NO_USER_WRITE_IN_WIPE: assert property (@(posedge clk) disable iff (!rst_n)
        zero_busy |-> !user_we); // R11

endmodule

// File: tb/secram_guard_tb.sv
`timescale 1ns/1ps
// Bench for secram_guard in its default size. It sweeps every word, every
// page against every domain and privilege, and checks wipe lengths.
module secram_guard_tb;
    localparam int WORDS = 1024;
    localparam int PW    = 64;
    localparam int MGR   = 15;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_write, req_secure;
    logic [9:0]  req_addr;
    logic [31:0] req_wdata;
    logic [3:0]  req_did;
    logic        rsp_valid, rsp_err;
    logic [31:0] rsp_rdata;
    logic        cfg_valid, cfg_assigned, cfg_secure, cfg_rd, cfg_wr;
    logic [3:0]  cfg_did, cfg_page, cfg_owner;
    logic        cfg_rsp_valid, cfg_rsp_err;
    logic        viol_in, zero_busy, zero_done;

    int n_vec = 0;
    int n_bad = 0;
    logic [31:0] mdl [WORDS];

    always #2 clk = ~clk;

    secram_guard u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_did(req_did), .req_secure(req_secure),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .cfg_valid(cfg_valid), .cfg_did(cfg_did), .cfg_page(cfg_page),
        .cfg_owner(cfg_owner), .cfg_assigned(cfg_assigned), .cfg_secure(cfg_secure),
        .cfg_rd(cfg_rd), .cfg_wr(cfg_wr),
        .cfg_rsp_valid(cfg_rsp_valid), .cfg_rsp_err(cfg_rsp_err),
        .viol_in(viol_in), .zero_busy(zero_busy), .zero_done(zero_done)
    );

    function automatic logic [31:0] pat(input int a);
        return 32'hC0DE_0000 ^ (a * 32'h0001_0007) ^ (a << 22);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One request, called at a falling edge; returns the registered answer.
    task automatic access(input logic wr, input int addr, input logic [31:0] wd,
                          input int did, input logic sec,
                          output logic err, output logic [31:0] rd);
        req_valid = 1'b1; req_write = wr; req_addr = addr[9:0];
        req_wdata = wd; req_did = did[3:0]; req_secure = sec;
        @(negedge clk);
        if (rsp_valid !== 1'b1) check("R2 rsp_valid", {31'd0, rsp_valid}, 32'd1);
        err = rsp_err; rd = rsp_rdata;
        req_valid = 1'b0;
    endtask

    task automatic configure(input int did, input int page, input int owner,
                             input logic asg, input logic sec, input logic rd,
                             input logic wr, input logic exp_err);
        cfg_valid = 1'b1; cfg_did = did[3:0]; cfg_page = page[3:0];
        cfg_owner = owner[3:0]; cfg_assigned = asg; cfg_secure = sec;
        cfg_rd = rd; cfg_wr = wr;
        @(negedge clk);
        check("R9 cfg answer", {30'd0, cfg_rsp_valid, cfg_rsp_err}, {30'd0, 1'b1, exp_err});
        cfg_valid = 1'b0;
    endtask

    // Counts busy cycles while probing that each request is refused.
    task automatic count_wipe(output int cnt);
        logic        e;
        logic [31:0] d;
        cnt = 0;
        while (zero_busy && cnt < 5000) begin
            cnt++;
            access(1'b0, 0, 32'd0, 0, 1'b1, e, d);
            check("R11 refused during wipe", {31'd0, e}, 32'd1);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic        e;
        logic [31:0] d;
        int          cnt;
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
        req_wdata = '0; req_did = '0; req_secure = 1'b0; cfg_valid = 1'b0;
        cfg_did = '0; cfg_page = '0; cfg_owner = '0; cfg_assigned = 1'b0;
        cfg_secure = 1'b0; cfg_rd = 1'b0; cfg_wr = 1'b0; viol_in = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 reset outputs", {28'd0, rsp_valid, cfg_rsp_valid, zero_busy, zero_done}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 idle no rsp", {31'd0, rsp_valid}, 32'd0);

        // R1 / R4: nothing is assigned after reset.
        access(1'b0, 0, 32'd0, 0, 1'b1, e, d);
        check("R4 unassigned after reset", {31'd0, e}, 32'd1);
        check("R8 zero data on error", d, 32'd0);

        // R9: manager assigns page p to domain p, odd pages secure-only.
        for (int p = 0; p < 16; p++) configure(MGR, p, p, 1'b1, p[0], 1'b1, 1'b1, 1'b0);

        // R3: fill and read back every word through its owner.
        for (int a = 0; a < WORDS; a++) begin
            access(1'b1, a, pat(a), a / PW, 1'b1, e, d);
            check("R3 write grant", {31'd0, e}, 32'd0);
            mdl[a] = pat(a);
        end
        for (int a = 0; a < WORDS; a++) begin
            access(1'b0, a, 32'd0, a / PW, 1'b1, e, d);
            check("R3 readback", d, mdl[a]);
        end

        // R5 / R6 / R8: every page against every domain and privilege.
        for (int p = 0; p < 16; p++)
            for (int dd = 0; dd < 16; dd++)
                for (int s = 0; s < 2; s++) begin
                    logic ok;
                    ok = (dd == p) && ((s == 1) || !p[0]);
                    access(1'b0, p * PW + 5, 32'd0, dd, s[0], e, d);
                    check("R5 R6 verdict", {31'd0, e}, {31'd0, !ok});
                    check("R8 data gating", d, ok ? mdl[p * PW + 5] : 32'd0);
                end

        // R8 / R6: refused writes leave page 3 untouched.
        for (int w = 0; w < PW; w++) begin
            access(1'b1, 3 * PW + w, ~pat(w), 4, 1'b1, e, d);
            check("R8 foreign write refused", {31'd0, e}, 32'd1);
            access(1'b1, 3 * PW + w, 32'hFFFF_0000, 3, 1'b0, e, d);
            check("R6 ns write refused", {31'd0, e}, 32'd1);
        end
        for (int w = 0; w < PW; w++) begin
            access(1'b0, 3 * PW + w, 32'd0, 3, 1'b1, e, d);
            check("R8 page unchanged", d, mdl[3 * PW + w]);
        end

        // R7: read and write permissions act separately.
        configure(MGR, 5, 5, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
        access(1'b0, 5 * PW + 1, 32'd0, 5, 1'b1, e, d);
        check("R7 read denied", {31'd0, e}, 32'd1);
        access(1'b1, 5 * PW + 1, 32'h1234_5678, 5, 1'b1, e, d);
        check("R7 write allowed", {31'd0, e}, 32'd0);
        mdl[5 * PW + 1] = 32'h1234_5678;
        configure(MGR, 5, 5, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
        access(1'b1, 5 * PW + 1, 32'hDEAD_BEEF, 5, 1'b1, e, d);
        check("R7 write denied", {31'd0, e}, 32'd1);
        access(1'b0, 5 * PW + 1, 32'd0, 5, 1'b1, e, d);
        check("R7 read allowed", d, 32'h1234_5678);

        // R9: a non-manager cannot take page 2.
        configure(3, 2, 3, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1);
        access(1'b0, 2 * PW, 32'd0, 3, 1'b1, e, d);
        check("R9 foreign cfg ignored", {31'd0, e}, 32'd1);
        access(1'b0, 2 * PW, 32'd0, 2, 1'b0, e, d);
        check("R9 owner kept", d, mdl[2 * PW]);

        // R4: unassigning page 7 locks out its former owner.
        configure(MGR, 7, 7, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
        access(1'b0, 7 * PW, 32'd0, 7, 1'b1, e, d);
        check("R4 unassigned refused", {31'd0, e}, 32'd1);
        configure(MGR, 7, 7, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);

        // R10 / R11: violation with a request in the same cycle.
        viol_in = 1'b1;
        access(1'b0, 0, 32'd0, 0, 1'b1, e, d);
        viol_in = 1'b0;
        check("R11 refused in violation cycle", {31'd0, e}, 32'd1);
        check("R10 busy/done after start", {30'd0, zero_busy, zero_done}, 32'd2);
        count_wipe(cnt);
        check("R10 wipe length", cnt, WORDS);
        check("R10 done raised", {31'd0, zero_done}, 32'd1);
        for (int a = 0; a < WORDS; a++) begin
            access(1'b0, a, 32'd0, a / PW, 1'b1, e, d);
            check("R11 records kept", {31'd0, e}, 32'd0);
            check("R10 word wiped", d, 32'd0);
        end

        // R12: second violation mid-wipe restarts the walk.
        viol_in = 1'b1;
        @(negedge clk);
        viol_in = 1'b0;
        repeat (99) @(negedge clk);
        check("R12 still busy, done clear", {30'd0, zero_busy, zero_done}, 32'd2);
        viol_in = 1'b1;
        @(negedge clk);
        viol_in = 1'b0;
        count_wipe(cnt);
        check("R12 restarted length", cnt, WORDS);
        check("R12 done after restart", {31'd0, zero_done}, 32'd1);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule